// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the internal address for a four-beat burst access to a synchronous memory. A starting address is captured from the external address bus when either address-status strobe is asserted. One strobe comes from the processor; the other comes from the cache controller. The upper address bits are held for the whole burst. The two lowest bits are generated from a two-bit beat counter, which steps once for each clock edge at which the active-low advance input is asserted.

A run-time order select chooses between two beat orders. Linear order adds the beat count to the starting low bits and wraps modulo four. Interleaved order XORs the beat count with the starting low bits. The block drives the complete internal address and the current beat index. The memory array and the data path are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_out is 0 and beat_idx is 0.
- R2: At an edge where ctrl_as_n is low, addr_in is captured and beat_idx becomes 0, whatever the level of chip_en_n.
- R3: At an edge where proc_as_n is low, the load takes place only if chip_en_n is also low. With chip_en_n high and ctrl_as_n high, the strobe is ignored: the upper address bits and beat_idx stay unchanged.
- R4: At an edge with no load and advance_n low, beat_idx increases by one.
- R5: At an edge with no load and advance_n high, beat_idx and the upper address bits hold their values.
- R6: When a load and advance_n low occur at the same edge, the load wins: beat_idx becomes 0 and the new address is captured.
- R7: addr_out[15:2] equals addr_in[15:2] from the most recent load, on every beat of the burst.
- R8: With order_sel = 0 (linear), addr_out[1:0] = (start + beat_idx) mod 4, where start is addr_in[1:0] from the last load.
- R9: With order_sel = 1 (interleaved), addr_out[1:0] = start XOR beat_idx.
- R10: An advance from beat_idx 3 wraps it to 0, which brings addr_out[1:0] back to the starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_in | input | 16 | External starting address |
| chip_en_n | input | 1 | Active-low chip enable; gates the processor strobe |
| proc_as_n | input | 1 | Active-low processor address-status strobe |
| ctrl_as_n | input | 1 | Active-low cache-controller address-status strobe |
| advance_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | Beat order: 0 selects linear, 1 selects interleaved |
| addr_out | output | 16 | Internal address for the current beat |
| beat_idx | output | 2 | Current beat number, 0 to 3 |

## Verification
All state sits one register behind the ports, and addr_out is derived from that state through logic only. A wrong count or a wrong captured address therefore appears on beat_idx or addr_out right after the faulty edge, and it stays visible until the next load. An error in the order logic appears on addr_out[1:0] as soon as order_sel or the count changes. A wrong strobe gate or a wrong load priority shows as a beat index that is not zero, or as stale upper bits, at the edge directly after the strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic chip_en_n,
  input  logic proc_as_n,
  input  logic ctrl_as_n,
  input  logic advance_n,
  output logic load,
  output logic step
);
  logic proc_ok;

  always_comb begin
    proc_ok = !proc_as_n && !chip_en_n;
    load    = !ctrl_as_n || proc_ok;
    step    = !advance_n && !load;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] count
);
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load || step;
    cnt_d  = load ? '0 : cnt_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_clear_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(load) |-> count == '0);

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(step) |-> count == BEAT_W'($past(count) + 1'b1));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(load) && !$past(step) |-> $stable(count));
endmodule

// File: rtl/burst_beat_order.sv
module burst_beat_order
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] count,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_low[b] = start[b] ^ count[b];
    end
  endgenerate

  always_comb begin
    lin_low = start + count;
    low     = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              chip_en_n,
  input  logic              proc_as_n,
  input  logic              ctrl_as_n,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat_idx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  logic              rst_q_n;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [BEAT_W-1:0] count;
  logic [BEAT_W-1:0] low;
  order_e            order;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  burst_load_ctrl u_ctrl (
    .chip_en_n(chip_en_n), .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n),
    .advance_n(advance_n), .load(load), .step(step)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .load(load), .step(step), .count(count)
  );

  always_comb begin
    base_d = addr_in;
    order  = order_e'(order_sel);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  base_q <= '0;
    else if (load) base_q <= base_d;
  end

  burst_beat_order #(.BEAT_W(BEAT_W)) u_ord (
    .start(base_q[BEAT_W-1:0]), .count(count), .order(order), .low(low)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low};
  assign beat_idx = count;

  assert_proc_gate_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) && $past(chip_en_n && ctrl_as_n && advance_n) |->
      $stable(beat_idx) && $stable(addr_out[ADDR_W-1:BEAT_W]));

  assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) && !$past(load) |->
      addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  assert_upper_load_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) && $past(load) |->
      addr_out[ADDR_W-1:BEAT_W] == $past(addr_in[ADDR_W-1:BEAT_W]));

  assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) && $past(step) && order_sel == 1'b0 && $past(order_sel) == 1'b0 |->
      addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));

  assert_interleave_step_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) && $past(step) && order_sel && $past(order_sel) |->
      (addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) == (beat_idx ^ $past(beat_idx)));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) && $past(step) && $past(beat_idx) == LAST_BEAT |->
      beat_idx == '0 && addr_out[BEAT_W-1:0] == base_q[BEAT_W-1:0]);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_q_n |-> addr_out == '0 && beat_idx == '0);
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr_in;
  logic        chip_en_n;
  logic        proc_as_n;
  logic        ctrl_as_n;
  logic        advance_n;
  logic        order_sel;
  logic [15:0] addr_out;
  logic [1:0]  beat_idx;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [15:0] mdl_base = '0;
  logic [1:0]  mdl_cnt  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .chip_en_n(chip_en_n),
    .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n), .advance_n(advance_n),
    .order_sel(order_sel), .addr_out(addr_out), .beat_idx(beat_idx)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] c, input logic m);
    return m ? (s ^ c) : 2'((s + c) % 4);
  endfunction

  task automatic check_outputs(input string beat_tag);
    chk(beat_tag, {14'd0, beat_idx}, {14'd0, mdl_cnt});
    chk("R7", {2'd0, addr_out[15:2]}, {2'd0, mdl_base[15:2]});
    chk(order_sel ? "R9" : "R8", {14'd0, addr_out[1:0]},
        {14'd0, exp_low(mdl_base[1:0], mdl_cnt, order_sel)});
  endtask

  task automatic step(input logic [15:0] a, input logic ce_n, input logic p_n,
                      input logic c_n, input logic adv_n, input logic ord);
    logic  ld;
    string tag;
    addr_in = a; chip_en_n = ce_n; proc_as_n = p_n; ctrl_as_n = c_n;
    advance_n = adv_n; order_sel = ord;
    @(posedge clk);
    ld = !c_n || (!p_n && !ce_n);
    if (ld) begin
      mdl_base = a;
      mdl_cnt  = '0;
      if (!adv_n)    tag = "R6";
      else if (!c_n) tag = "R2";
      else           tag = "R3";
    end else if (!adv_n) begin
      mdl_cnt = mdl_cnt + 2'd1;
      tag = (mdl_cnt == 2'd0) ? "R10" : "R4";
    end else begin
      tag = (!p_n) ? "R3" : "R5";
    end
    #1;
    check_outputs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_in = '0; chip_en_n = 1'b1; proc_as_n = 1'b1;
    ctrl_as_n = 1'b1; advance_n = 1'b1; order_sel = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", addr_out, 16'h0000);
    chk("R1", {14'd0, beat_idx}, 16'h0000);

    for (int src = 0; src < 2; src++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          logic [15:0] a;
          logic [15:0] b;
          a = 16'((s * 16'h1237 + m * 16'h0915 + src * 16'h3001) << 2) | 16'(s);
          b = ~a;
          // load from the chosen strobe
          if (src == 0) step(a, 1'b1, 1'b1, 1'b0, 1'b1, m[0]);
          else          step(a, 1'b0, 1'b0, 1'b1, 1'b1, m[0]);
          // four beats and a wrap (R4, R10)
          for (int k = 0; k < 5; k++) step(b, 1'b1, 1'b1, 1'b1, 1'b0, m[0]);
          // hold (R5)
          step(b, 1'b0, 1'b1, 1'b1, 1'b1, m[0]);
          // order switch mid-burst (R8/R9 combinational)
          step(b, 1'b1, 1'b1, 1'b1, 1'b0, ~m[0]);
          // ignored processor strobe with chip disabled (R3)
          step(b, 1'b1, 1'b0, 1'b1, 1'b1, m[0]);
          // cache strobe ignores chip enable (R2)
          step(b, 1'b1, 1'b1, 1'b0, 1'b1, m[0]);
          step(a, 1'b1, 1'b1, 1'b1, 1'b0, m[0]);
          // load wins over advance (R6)
          step(a, 1'b0, 1'b0, 1'b1, 1'b0, m[0]);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule